// File: doc/BRIEF.md
# Half-Bridge Gate Controller with Dead Time

This block turns a pair of logic control inputs into two registered gate enables: one for the high-side switch that pulls the output to the upper (ground) rail, and one for the low-side switch that pulls it to the negative rail. When neither switch conducts, the output floats. A mode input selects between two schemes. In dual-input mode each control input steers its own switch, and a fixed truth table applies. In single-input mode one input selects the rail, and a clocked dead time separates one switch turning off from the other turning on.

An active-low enable forces both switches off. Each switch has its own over-current sense flag. A trip cuts the conducting switch for the rest of the current pulse. In dual-input mode, the input combination that would turn on both switches is blocked and reported with a one-cycle flag. The dead time is the parameter `DEAD_CYC`, given in clock cycles. For example, 20 cycles at 100 MHz gives 200 ns.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset and at its release, `hi_on_o`, `lo_on_o` and `illegal_o` are 0, and `out_drive_o` is 2'b00.
- R2: When `mode_i`=1 and `en_ni`=0, the outputs follow `p_in_i` and `n_in_i` one clock edge later:
  - p=0 and n=0 turn on the high side only.
  - p=1 and n=0 turn both switches off.
  - p=1 and n=1 turn on the low side only.
- R3: When `mode_i`=1 and `en_ni`=0, the combination p=0, n=1 is forbidden. Both switches are off one edge later and stay off while the combination lasts. `illegal_o` is 1 for exactly the one cycle after the combination first appears.
- R4: When `mode_i`=0, `n_in_i`=0 commands the high side and `n_in_i`=1 commands the low side. `p_in_i` has no effect.
- R5: When `mode_i`=0, any change of the commanded switch pair at a clock edge turns both switches off for `DEAD_CYC` cycles. The newly commanded switch turns on at the `DEAD_CYC`+1-th edge. Each further change restarts this count.
- R6: When `en_ni`=1 at a clock edge, both switches are off after that edge, whatever the other inputs are.
- R7: If a switch's sense flag is 1 at an edge while that switch is on, the switch is off after that edge. It stays off, even when the flag clears, until its command goes away. It turns on again only at a later new command.
- R8: A sense flag that is set while its switch is off has no effect.
- R9: `hi_on_o` and `lo_on_o` are never 1 together, in any mode, including during mode or enable changes.
- R10: `out_drive_o` encodes the output state:
  - 2'b01 means driven to the upper rail (high side on).
  - 2'b10 means driven to the negative rail (low side on).
  - 2'b00 means high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_in_i | input | 1 | High-side control (dual mode: 1 turns high side off) |
| n_in_i | input | 1 | Low-side control (dual mode) / rail select (single mode) |
| mode_i | input | 1 | 1 = dual-input mode, 0 = single-input mode with dead time |
| en_ni | input | 1 | Enable, active low |
| oc_hi_i | input | 1 | Over-current sense for the high-side switch |
| oc_lo_i | input | 1 | Over-current sense for the low-side switch |
| hi_on_o | output | 1 | High-side gate enable (registered) |
| lo_on_o | output | 1 | Low-side gate enable (registered) |
| out_drive_o | output | 2 | Output state code |
| illegal_o | output | 1 | One-cycle flag for a forbidden dual-mode input combination |

## Verification
Every result except the dead-time release appears one clock edge after the inputs are sampled. This covers the gate enables, the state code, the forbidden-state flag, the enable cutoff and the over-current cutoff. In single mode, the newly commanded switch appears at the `DEAD_CYC`+1-th edge after the command change. The bench changes inputs only on falling edges and compares every output at the next falling edge against a cycle-stepped model. The directed dead-time checks count edges explicitly: off after each of the first `DEAD_CYC` edges, on after the next.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NUM_SW = 2;
  localparam int SW_HI  = 0;
  localparam int SW_LO  = 1;

  typedef enum logic [1:0] {
    DRV_OPEN  = 2'b00,
    DRV_UPPER = 2'b01,
    DRV_NEG   = 2'b10
  } drive_e;
endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  logic              p_in_i,
  input  logic              n_in_i,
  input  logic              mode_i,
  input  logic              en_ni,
  output logic [NUM_SW-1:0] req_o,
  output logic              forbid_o
);
  always_comb begin
    forbid_o = ~en_ni & mode_i & n_in_i & ~p_in_i;
    req_o    = '0;
    if (!en_ni) begin
      if (mode_i) begin
        // forbidden pair would short the rails: drop both
        req_o[SW_HI] = ~p_in_i & ~forbid_o;
        req_o[SW_LO] = n_in_i & ~forbid_o;
      end else begin
        req_o[SW_HI] = ~n_in_i;
        req_o[SW_LO] = n_in_i;
      end
    end
  end
endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              single_i,
  input  logic [NUM_SW-1:0] req_i,
  output logic              blank_o
);
  localparam int CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYC - 1);

  logic [NUM_SW-1:0] req_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              change;

  assign change  = (req_i != req_q);
  assign blank_o = single_i & (change | (cnt_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      cnt_q <= '0;
    end else begin
      req_q <= req_i;
      if (!single_i)          cnt_q <= '0;
      else if (change)        cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hb_oc_guard.sv
module hb_oc_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sense_i,
  input  logic gate_i,
  output logic cut_o
);
  logic lat_q;

  // trip only counts while the switch conducts
  assign cut_o = lat_q | (sense_i & gate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= 1'b0;
    else if (!req_i)  lat_q <= 1'b0;
    else              lat_q <= cut_o;
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       p_in_i,
  input  logic       n_in_i,
  input  logic       mode_i,
  input  logic       en_ni,
  input  logic       oc_hi_i,
  input  logic       oc_lo_i,
  output logic       hi_on_o,
  output logic       lo_on_o,
  output logic [1:0] out_drive_o,
  output logic       illegal_o
);
  logic [NUM_SW-1:0] req;
  logic [NUM_SW-1:0] sense;
  logic [NUM_SW-1:0] cut;
  logic [NUM_SW-1:0] gate_d;
  logic [NUM_SW-1:0] gate_q;
  logic              forbid;
  logic              forbid_q;
  logic              illegal_q;
  logic              blank;

  assign sense[SW_HI] = oc_hi_i;
  assign sense[SW_LO] = oc_lo_i;

  hb_cmd_decode u_dec (
    .p_in_i  (p_in_i),
    .n_in_i  (n_in_i),
    .mode_i  (mode_i),
    .en_ni   (en_ni),
    .req_o   (req),
    .forbid_o(forbid)
  );

  hb_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .single_i(~mode_i),
    .req_i   (req),
    .blank_o (blank)
  );

  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    hb_oc_guard u_oc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[s]),
      .sense_i(sense[s]),
      .gate_i (gate_q[s]),
      .cut_o  (cut[s])
    );
    assign gate_d[s] = req[s] & ~blank & ~cut[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q    <= '0;
      forbid_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      gate_q    <= gate_d;
      forbid_q  <= forbid;
      illegal_q <= forbid & ~forbid_q;
    end
  end

  assign hi_on_o   = gate_q[SW_HI];
  assign lo_on_o   = gate_q[SW_LO];
  assign illegal_o = illegal_q;

  always_comb begin
    unique case (gate_q)
      2'b01:   out_drive_o = DRV_UPPER;
      2'b10:   out_drive_o = DRV_NEG;
      default: out_drive_o = DRV_OPEN;
    endcase
  end
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       p_in_i,
  input logic       n_in_i,
  input logic       mode_i,
  input logic       en_ni,
  input logic       oc_hi_i,
  input logic       oc_lo_i,
  input logic       hi_on_o,
  input logic       lo_on_o,
  input logic [1:0] out_drive_o,
  input logic       illegal_o
);
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_on_o && lo_on_o)); // R9

  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> (!hi_on_o && !lo_on_o)); // R6

  AST_FORBID_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && mode_i && n_in_i && !p_in_i) |=> (!hi_on_o && !lo_on_o)); // R3

  AST_ILLEGAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o); // R3

  AST_OC_HI_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_hi_i && hi_on_o) |=> !hi_on_o); // R7

  AST_OC_LO_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_lo_i && lo_on_o) |=> !lo_on_o); // R7

  AST_SINGLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && (hi_on_o || lo_on_o)) |=> !(hi_on_o != $past(hi_on_o) && lo_on_o != $past(lo_on_o))); // R5

  AST_DRIVE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_on_o && !lo_on_o) |-> (out_drive_o == 2'b00)); // R10
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (.*);

// File: tb/hb_gate_ctrl_test.sv
module hb_gate_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       p_in = 1'b0, n_in = 1'b0, mode = 1'b1, en_n = 1'b1;
  logic       oc_hi = 1'b0, oc_lo = 1'b0;
  logic       hi_on, lo_on, illegal;
  logic [1:0] drive;

  int total = 0;
  int bad = 0;

  // reference state
  logic md_hi = 0, md_lo = 0, md_ill = 0, md_fq = 0, md_lh = 0, md_ll = 0;
  logic [1:0] md_prev = 2'b00;
  int md_cnt = 0;

  hb_gate_ctrl #(.DEAD_CYC(DEAD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .p_in_i(p_in), .n_in_i(n_in), .mode_i(mode),
    .en_ni(en_n), .oc_hi_i(oc_hi), .oc_lo_i(oc_lo), .hi_on_o(hi_on),
    .lo_on_o(lo_on), .out_drive_o(drive), .illegal_o(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] exp_drive(logic h, logic l);
    return h ? 2'b01 : (l ? 2'b10 : 2'b00);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic en, forb, rh, rl, single, change, blank, th, tl;
    en     = ~en_n;
    forb   = en & mode & n_in & ~p_in;
    rh     = en & (mode ? (~p_in & ~forb) : ~n_in);
    rl     = en & (mode ? (n_in & ~forb) : n_in);
    single = ~mode;
    change = ({rl, rh} != md_prev);
    blank  = single & (change | (md_cnt != 0));
    th     = md_lh | (oc_hi & md_hi);
    tl     = md_ll | (oc_lo & md_lo);
    md_hi  = rh & ~blank & ~th;
    md_lo  = rl & ~blank & ~tl;
    md_lh  = rh ? th : 1'b0;
    md_ll  = rl ? tl : 1'b0;
    if (!single)          md_cnt = 0;
    else if (change)      md_cnt = DEAD - 1;
    else if (md_cnt != 0) md_cnt = md_cnt - 1;
    md_ill  = forb & ~md_fq;
    md_fq   = forb;
    md_prev = {rl, rh};
  endtask

  // one clock: drive at falling edge, model at rising, compare at next falling
  task automatic cyc(logic p, logic n, logic m, logic e, logic oh, logic ol);
    string tag;
    p_in = p; n_in = n; mode = m; en_n = e; oc_hi = oh; oc_lo = ol;
    tag = e ? "R6" : (m ? "R2" : "R4_R5");
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " hi"}, hi_on, md_hi);
    chk({tag, " lo"}, lo_on, md_lo);
    chk("R3 illegal", illegal, md_ill);
    chk("R10 drive", drive, exp_drive(md_hi, md_lo));
    chk("R9 overlap", hi_on & lo_on, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    chk("R1 hi", hi_on, 0);
    chk("R1 lo", lo_on, 0);
    chk("R1 illegal", illegal, 0);
    chk("R1 drive", drive, 0);
    rst_n = 1'b1;
    chk("R1 drive at release", drive, 0);

    // R2 dual-mode truth table
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2 p0n0 hi", hi_on, 1); chk("R10 upper", drive, 2'b01);
    cyc(1, 0, 1, 0, 0, 0);
    chk("R2 p1n0 open", drive, 2'b00);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R2 p1n1 lo", lo_on, 1); chk("R10 neg", drive, 2'b10);

    // R3 forbidden combination
    cyc(0, 1, 1, 0, 0, 0);
    chk("R3 off", hi_on | lo_on, 0); chk("R3 flag", illegal, 1);
    cyc(0, 1, 1, 0, 0, 0);
    chk("R3 flag one cycle", illegal, 0); chk("R3 still off", hi_on | lo_on, 0);

    // R6 enable high
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0);
    chk("R6 disabled", hi_on | lo_on, 0);

    // R5 dead time in single mode, then R4 p ignored
    for (int i = 0; i < DEAD; i++) begin
      cyc(1, 0, 0, 0, 0, 0);
      chk("R5 gap hi", hi_on, 0);
    end
    cyc(1, 0, 0, 0, 0, 0);
    chk("R5 hi after gap", hi_on, 1);
    for (int i = 0; i < DEAD; i++) begin
      cyc(0, 1, 0, 0, 0, 0);
      chk("R5 gap both", hi_on | lo_on, 0);
    end
    cyc(1, 1, 0, 0, 0, 0);
    chk("R4 lo on, p ignored", lo_on, 1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R4 p toggle no effect", lo_on, 1);

    // R7 over-current latch in dual mode
    cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 1);
    chk("R7 lo cut", lo_on, 0);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R7 lo held off", lo_on, 0);
    cyc(1, 0, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R7 lo re-armed", lo_on, 1);

    // R8 sense while off ignored
    cyc(1, 0, 1, 0, 1, 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R8 hi on after idle trip", hi_on, 1);

    // random phase
    for (int blk = 0; blk < 400; blk++) begin
      logic p, n, m, e;
      int hold;
      p = 1'($urandom); n = 1'($urandom);
      m = ($urandom % 4) != 0; e = ($urandom % 8) == 0;
      hold = 1 + ($urandom % 30);
      for (int k = 0; k < hold; k++)
        cyc(p, n, m, e, ($urandom % 16) == 0, ($urandom % 16) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule